// File: doc/BRIEF.md
# Nibble-Mode Reverse Channel Receiver

This block is the host end of the reverse (peripheral-to-host) channel of a byte-wide parallel port that runs in nibble mode. A request pulse carries the number of bytes the host wants. The block moves one handshake line toward the peripheral (HostBusy) and watches five status lines: the nibble clock, the busy line, the acknowledge/data-request line, the extension flag and the active-low data-available line. Each byte is taken as two 4-bit halves carried on four of those status lines.

The block keeps a link phase register: after-negotiation, reverse idle, reverse transfer, or unknown. The phase decides where a request begins. The link may be parked in idle and checked, woken through an interrupt exchange, or read directly. Every assembled byte is presented for one cycle with a valid strobe. Each request ends with a one-cycle done pulse that carries the byte count. A handshake timeout or a bad idle line raises an error flag, and that flag stays up until the next request. The status lines are brought into the clock domain through a flop synchronizer. Timeouts and the idle entry stall are counted in clock cycles.

Top module: `nibble_rx_host`

## Requirements
- R1: After reset the phase output is unknown (code 3), `host_busy` is 1, and `done`, `error` and `byte_valid` are 0. A request made while the phase is unknown ends with `done`, `error`=1, a count of 0 and the phase left at 3.
- R2: A request in the after-negotiation phase (code 0) with `n_data_avail` high holds `host_busy` high for at least STALL_CYC cycles after the request. It then drives `host_busy` low, sets the phase to reverse idle (code 1) and continues with the idle check.
- R3: A request in the after-negotiation phase with `n_data_avail` low sets the phase to reverse transfer (code 2) and starts reading nibbles at once, with no stall and no interrupt exchange.
- R4: In reverse idle with `n_data_avail` low, the block drives `host_busy` high and waits for `ack_data_req` low. Seeing it moves to transfer. Not seeing it within TIMEOUT_CYC cycles ends with `error`=1 and phase 3.
- R5: In reverse idle with `n_data_avail` high, the block ends with a count of 0 and the phase kept at 1 when `ack_data_req` is 1 and `xflag` is 0. Any other combination ends with `error`=1 and phase 3.
- R6: For each nibble the block drives `host_busy` low and waits for `ptr_clk` low. It then samples the status lines, drives `host_busy` high and waits for `ptr_clk` high. Missing either edge for TIMEOUT_CYC cycles ends with `error`=1, phase 3, and no timeout reported sooner than TIMEOUT_CYC cycles after the wait began.
- R7: A nibble is {ptr_busy, ack_data_req, xflag, n_data_avail} as pin levels, bit 3 down to bit 0. The first nibble of a byte forms `byte_data[3:0]` and the second forms `byte_data[7:4]`. Each byte is shown with a one-cycle `byte_valid`.
- R8: After each byte, `n_data_avail` high ends the request successfully. The byte is counted, the phase becomes reverse idle, and this happens even when fewer bytes than requested were read.
- R9: When the requested count is reached with `n_data_avail` still low, the request ends with phase 2 and `host_busy` high. A request for 0 bytes in transfer ends with a count of 0 and no byte.
- R10: A request that ends successfully in reverse idle leaves `host_busy` low.
- R11: `done` is a single-cycle pulse per request, with `bytes_transferred` valid while it is high. `error` stays set until the next request is accepted.
- R12: A `nego_load` pulse while no request is running sets the phase to after-negotiation and drives `host_busy` high. If `start` is high in the same cycle, `start` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nego_load | input | 1 | Marks negotiation complete; sets phase to after-negotiation |
| start | input | 1 | Begins a read request |
| req_count | input | CNT_W | Number of bytes requested |
| ptr_clk | input | 1 | Peripheral nibble clock |
| ptr_busy | input | 1 | Peripheral busy line, nibble bit 3 |
| ack_data_req | input | 1 | Acknowledge/data request line, nibble bit 2 |
| xflag | input | 1 | Extension flag line, nibble bit 1 |
| n_data_avail | input | 1 | Active-low data available, nibble bit 0 |
| host_busy | output | 1 | Host handshake line to the peripheral |
| byte_valid | output | 1 | One-cycle strobe for an assembled byte |
| byte_data | output | 8 | Assembled byte |
| done | output | 1 | One-cycle end-of-request pulse |
| bytes_transferred | output | CNT_W | Bytes read by the request just ended |
| error | output | 1 | Device error, held until the next request |
| phase | output | 2 | Link phase: 0 after-negotiation, 1 idle, 2 transfer, 3 unknown |

## Verification
The properties take for granted that `start` and `nego_load` are only pulsed while no request is running, and that the status lines change slowly next to the synchronizer depth. The data lines are set up at least one cycle before the nibble clock edge that qualifies them. The bench peripheral drives its lines only on the falling clock edge and waits a full cycle between setting the data and moving `ptr_clk`. It sets `n_data_avail` for the next byte before it raises the clock after the second nibble. It sends no request pulse until the previous done has been observed. Silent-peripheral and bad-idle cases are produced by switching the peripheral model off or by forcing `xflag`, never by glitching lines in the middle of a nibble.

// File: rtl/nrx_pkg.sv
package nrx_pkg;

    typedef enum logic [1:0] {
        PH_NEGO = 2'd0,
        PH_IDLE = 2'd1,
        PH_XFER = 2'd2,
        PH_UNK  = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        ST_WAIT     = 3'd0,
        ST_STALL    = 3'd1,
        ST_IDLE_CHK = 3'd2,
        ST_INT_WAIT = 3'd3,
        ST_NIB_LO   = 3'd4,
        ST_NIB_HI   = 3'd5
    } fsm_e;

    // synchronized status lines
    typedef struct packed {
        logic pclk;
        logic busy;
        logic ack;
        logic xf;
        logic ndav;
    } stat_t;

    localparam int STAT_W = 5;
    // line levels of an idle, healthy link
    localparam logic [STAT_W-1:0] STAT_IDLE = 5'b10101;

endpackage

// File: rtl/nrx_sync.sv
module nrx_sync #(
    parameter int              W       = 5,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/nrx_timer.sv
module nrx_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_d, cnt_q;

    assign hit = (cnt_q >= limit);

    always_comb begin
        if (clr)      cnt_d = '0;
        else if (hit) cnt_d = cnt_q;
        else          cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/nrx_nibble_pack.sv
module nrx_nibble_pack (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_lo,
    input  logic       cap_hi,
    input  logic [3:0] nib,
    output logic [7:0] byte_o
);
    logic [3:0] lo_d, lo_q, hi_d, hi_q;

    always_comb begin
        lo_d = cap_lo ? nib : lo_q;
        hi_d = cap_hi ? nib : hi_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    assign byte_o = {hi_q, lo_q};
endmodule

// File: rtl/nibble_rx_host.sv
module nibble_rx_host
    import nrx_pkg::*;
#(
    parameter int TIMEOUT_CYC = 256,
    parameter int STALL_CYC   = 8,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nego_load,
    input  logic             start,
    input  logic [CNT_W-1:0] req_count,
    input  logic             ptr_clk,
    input  logic             ptr_busy,
    input  logic             ack_data_req,
    input  logic             xflag,
    input  logic             n_data_avail,
    output logic             host_busy,
    output logic             byte_valid,
    output logic [7:0]       byte_data,
    output logic             done,
    output logic [CNT_W-1:0] bytes_transferred,
    output logic             error,
    output logic [1:0]       phase
);
    localparam int MAX_WAIT = (TIMEOUT_CYC > STALL_CYC) ? TIMEOUT_CYC : STALL_CYC;
    localparam int TW       = $clog2(MAX_WAIT + 1);
    localparam logic [TW-1:0] TO_LIM = TW'(TIMEOUT_CYC);
    localparam logic [TW-1:0] ST_LIM = TW'(STALL_CYC);

    typedef struct packed {
        fsm_e             st;
        phase_e           ph;
        logic             hb;
        logic             nib_hi;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] req;
        logic             err;
        logic             done;
        logic             bv;
    } regs_t;

    regs_t r_q, r_d;

    // ---------------- status synchronizer ----------------
    stat_t          s;
    logic [STAT_W-1:0] raw_stat, sync_stat;

    assign raw_stat = {ptr_clk, ptr_busy, ack_data_req, xflag, n_data_avail};

    nrx_sync #(
        .W      (STAT_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(STAT_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_stat),
        .q    (sync_stat)
    );

    assign s = stat_t'(sync_stat);

    // ---------------- wait timer ----------------
    logic          tmr_clr, tmr_hit;
    logic [TW-1:0] tmr_lim;

    assign tmr_lim = (r_q.st == ST_STALL) ? ST_LIM : TO_LIM;
    assign tmr_clr = (r_d.st != r_q.st) || (r_q.st == ST_WAIT);

    nrx_timer #(.W(TW)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .limit(tmr_lim),
        .hit  (tmr_hit)
    );

    // ---------------- nibble assembly ----------------
    logic       clk_low_seen;
    logic [3:0] nib_now;

    assign clk_low_seen = (r_q.st == ST_NIB_LO) && !s.pclk;
    assign nib_now      = {s.busy, s.ack, s.xf, s.ndav};

    nrx_nibble_pack u_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_lo(clk_low_seen && !r_q.nib_hi),
        .cap_hi(clk_low_seen &&  r_q.nib_hi),
        .nib   (nib_now),
        .byte_o(byte_data)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        logic [CNT_W-1:0] cnt_inc;
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.bv   = 1'b0;
        cnt_inc  = r_q.cnt + CNT_W'(1);

        unique case (r_q.st)
            ST_WAIT: begin
                if (start) begin
                    r_d.err = 1'b0;
                    r_d.cnt = '0;
                    r_d.req = req_count;
                    unique case (r_q.ph)
                        PH_NEGO: begin
                            if (s.ndav) begin
                                r_d.st = ST_STALL;
                            end else begin
                                r_d.ph = PH_XFER;
                                if (req_count == '0) begin
                                    r_d.done = 1'b1;
                                end else begin
                                    r_d.hb     = 1'b0;
                                    r_d.nib_hi = 1'b0;
                                    r_d.st     = ST_NIB_LO;
                                end
                            end
                        end
                        PH_IDLE: r_d.st = ST_IDLE_CHK;
                        PH_XFER: begin
                            if (req_count == '0) begin
                                r_d.done = 1'b1;
                            end else begin
                                r_d.hb     = 1'b0;
                                r_d.nib_hi = 1'b0;
                                r_d.st     = ST_NIB_LO;
                            end
                        end
                        default: begin
                            r_d.err  = 1'b1;
                            r_d.ph   = PH_UNK;
                            r_d.done = 1'b1;
                        end
                    endcase
                end else if (nego_load) begin
                    r_d.ph = PH_NEGO;
                    r_d.hb = 1'b1;
                end
            end

            ST_STALL: begin
                if (tmr_hit) begin
                    r_d.hb = 1'b0;
                    r_d.ph = PH_IDLE;
                    r_d.st = ST_IDLE_CHK;
                end
            end

            ST_IDLE_CHK: begin
                if (!s.ndav) begin
                    r_d.hb = 1'b1;
                    r_d.st = ST_INT_WAIT;
                end else if (s.ack && !s.xf) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_WAIT;
                end else begin
                    r_d.err  = 1'b1;
                    r_d.ph   = PH_UNK;
                    r_d.done = 1'b1;
                    r_d.st   = ST_WAIT;
                end
            end

            ST_INT_WAIT: begin
                if (!s.ack) begin
                    r_d.ph = PH_XFER;
                    if (r_q.req == '0) begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_WAIT;
                    end else begin
                        r_d.hb     = 1'b0;
                        r_d.nib_hi = 1'b0;
                        r_d.st     = ST_NIB_LO;
                    end
                end else if (tmr_hit) begin
                    r_d.err  = 1'b1;
                    r_d.ph   = PH_UNK;
                    r_d.done = 1'b1;
                    r_d.st   = ST_WAIT;
                end
            end

            ST_NIB_LO: begin
                if (!s.pclk) begin
                    r_d.hb = 1'b1;
                    r_d.st = ST_NIB_HI;
                end else if (tmr_hit) begin
                    r_d.err  = 1'b1;
                    r_d.ph   = PH_UNK;
                    r_d.done = 1'b1;
                    r_d.st   = ST_WAIT;
                end
            end

            ST_NIB_HI: begin
                if (s.pclk) begin
                    if (!r_q.nib_hi) begin
                        r_d.nib_hi = 1'b1;
                        r_d.hb     = 1'b0;
                        r_d.st     = ST_NIB_LO;
                    end else begin
                        r_d.bv  = 1'b1;
                        r_d.cnt = cnt_inc;
                        if (s.ndav) begin
                            r_d.ph   = PH_IDLE;
                            r_d.hb   = 1'b0;
                            r_d.done = 1'b1;
                            r_d.st   = ST_WAIT;
                        end else if (cnt_inc == r_q.req) begin
                            r_d.done = 1'b1;
                            r_d.st   = ST_WAIT;
                        end else begin
                            r_d.nib_hi = 1'b0;
                            r_d.hb     = 1'b0;
                            r_d.st     = ST_NIB_LO;
                        end
                    end
                end else if (tmr_hit) begin
                    r_d.err  = 1'b1;
                    r_d.ph   = PH_UNK;
                    r_d.done = 1'b1;
                    r_d.st   = ST_WAIT;
                end
            end

            default: r_d.st = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_WAIT;
            r_q.ph     <= PH_UNK;
            r_q.hb     <= 1'b1;
            r_q.nib_hi <= 1'b0;
            r_q.cnt    <= '0;
            r_q.req    <= '0;
            r_q.err    <= 1'b0;
            r_q.done   <= 1'b0;
            r_q.bv     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign host_busy         = r_q.hb;
    assign byte_valid        = r_q.bv;
    assign done              = r_q.done;
    assign bytes_transferred = r_q.cnt;
    assign error             = r_q.err;
    assign phase             = r_q.ph;

endmodule

// File: rtl/nibble_rx_host_chk.sv
module nibble_rx_host_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             host_busy,
    input logic             byte_valid,
    input logic             done,
    input logic [CNT_W-1:0] bytes_transferred,
    input logic             error,
    input logic [1:0]       phase
);
    // R11
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);

    // R1
    unk_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && error) |-> (phase == 2'd3));

    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !error && phase == 2'd1) |-> !host_busy);

    // R7
    byte_noerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> !error);

    // R8
    byte_counted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> (bytes_transferred != '0));
endmodule

bind nibble_rx_host nibble_rx_host_chk #(.CNT_W(CNT_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .start            (start),
    .host_busy        (host_busy),
    .byte_valid       (byte_valid),
    .done             (done),
    .bytes_transferred(bytes_transferred),
    .error            (error),
    .phase            (phase)
);

// File: tb/nibble_rx_host_test.sv
module nibble_rx_host_test;
    localparam int TO  = 40;
    localparam int STL = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nego_load = 1'b0;
    logic        start = 1'b0;
    logic [15:0] req_count = '0;
    logic        p_clk = 1'b1, p_busy = 1'b0, p_ack = 1'b1, p_xf = 1'b0, p_nd = 1'b1;
    logic        host_busy, byte_valid, done, error;
    logic [7:0]  byte_data;
    logic [15:0] bytes_transferred;
    logic [1:0]  phase;

    always #2 clk = ~clk;

    nibble_rx_host #(.TIMEOUT_CYC(TO), .STALL_CYC(STL)) uut (
        .clk(clk), .rst_n(rst_n), .nego_load(nego_load), .start(start),
        .req_count(req_count), .ptr_clk(p_clk), .ptr_busy(p_busy),
        .ack_data_req(p_ack), .xflag(p_xf), .n_data_avail(p_nd),
        .host_busy(host_busy), .byte_valid(byte_valid), .byte_data(byte_data),
        .done(done), .bytes_transferred(bytes_transferred), .error(error),
        .phase(phase)
    );

    int n_chk = 0, n_bad = 0;
    logic [7:0] pq[$];     // peripheral send queue
    logic [7:0] exp_q[$];  // reference of bytes the host must deliver
    bit serve_en = 0, p_xfer = 0, half = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural peripheral
    initial begin
        forever begin
            @(negedge clk);
            if (serve_en && !p_xfer && host_busy && !p_nd && p_ack) begin
                p_ack  = 1'b0;
                p_xfer = 1'b1;
            end else if (serve_en && p_xfer && !host_busy && p_clk && pq.size() > 0) begin
                logic [3:0] nb;
                nb = half ? pq[0][7:4] : pq[0][3:0];
                {p_busy, p_ack, p_xf, p_nd} = nb;
                @(negedge clk);
                p_clk = 1'b0;
                while (!host_busy) @(negedge clk);
                if (half) begin
                    void'(pq.pop_front());
                    p_busy = 1'b0; p_ack = 1'b1; p_xf = 1'b0;
                    p_nd   = (pq.size() == 0);
                    if (pq.size() == 0) p_xfer = 1'b0;
                end
                half = !half;
                @(negedge clk);
                p_clk = 1'b1;
            end
        end
    end

    // per-clock byte comparison against the reference queue (R7)
    always @(negedge clk) begin
        if (rst_n && byte_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R7 unexpected byte", byte_data, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(byte_data == e, "R7 byte value", byte_data, e);
            end
        end
    end

    int dn_cyc, hb_fall;
    logic [15:0] g_cnt; logic g_err; logic [1:0] g_ph; logic g_hb;

    task automatic run(input logic [15:0] n);
        req_count = n;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dn_cyc = 1; hb_fall = -1;
        while (!done && dn_cyc < 3000) begin
            if (hb_fall < 0 && !host_busy) hb_fall = dn_cyc;
            @(negedge clk);
            dn_cyc++;
        end
        g_cnt = bytes_transferred; g_err = error; g_ph = phase;
        @(negedge clk);
        g_hb = host_busy;
        chk(!done, "R11 done single pulse", done, 0);
    endtask

    task automatic nego();
        nego_load = 1'b1;
        @(negedge clk);
        nego_load = 1'b0;
        @(negedge clk);
        chk(phase == 2'd0, "R12 phase after nego_load", phase, 0);
        chk(host_busy == 1'b1, "R12 host_busy after nego_load", host_busy, 1);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(phase == 2'd3, "R1 reset phase", phase, 3);
        chk(host_busy == 1'b1, "R1 reset host_busy", host_busy, 1);
        chk(!done && !error && !byte_valid, "R1 reset outputs", {done, error, byte_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 request in unknown phase
        run(16'd3);
        chk(g_err == 1'b1 && g_cnt == 0 && g_ph == 2'd3, "R1 unknown-phase request", {g_err, g_cnt, g_ph}, {1'b1, 16'd0, 2'd3});

        // R2 R5 R10: negotiation with no data, healthy idle
        nego();
        run(16'd4);
        chk(hb_fall >= STL, "R2 stall length", hb_fall, STL);
        chk(!g_err && g_cnt == 0 && g_ph == 2'd1, "R5 healthy idle", {g_err, g_cnt, g_ph}, {1'b0, 16'd0, 2'd1});
        chk(g_hb == 1'b0, "R10 host_busy low in idle", g_hb, 0);

        // R4 R6 R7 R8: interrupt phase, early end after two bytes
        pq = '{8'hA5, 8'h3C}; exp_q = '{8'hA5, 8'h3C};
        half = 0; p_xfer = 0; serve_en = 1; p_nd = 1'b0;
        settle();
        run(16'd4);
        chk(!g_err && g_cnt == 2 && g_ph == 2'd1, "R8 early end count/phase", {g_err, g_cnt, g_ph}, {1'b0, 16'd2, 2'd1});
        chk(g_hb == 1'b0, "R10 host_busy low after early end", g_hb, 0);
        chk(exp_q.size() == 0, "R4 bytes via interrupt phase", exp_q.size(), 0);

        // R5 bad idle: xflag high
        serve_en = 0; p_xf = 1'b1; settle();
        run(16'd2);
        chk(g_err && g_cnt == 0 && g_ph == 2'd3, "R5 bad idle error", {g_err, g_cnt, g_ph}, {1'b1, 16'd0, 2'd3});
        repeat (10) @(negedge clk);
        chk(error == 1'b1, "R11 error held", error, 1);
        p_xf = 1'b0;

        // R3 R9: direct transfer, count reached, then remainder
        nego();
        chk(error == 1'b1, "R11 error held over nego_load", error, 1);
        pq = '{8'h5A, 8'hF0, 8'h0F}; exp_q = '{8'h5A, 8'hF0, 8'h0F};
        half = 0; p_nd = 1'b0; p_xfer = 1; serve_en = 1; settle();
        run(16'd2);
        chk(!g_err && g_cnt == 2 && g_ph == 2'd2, "R9 count reached", {g_err, g_cnt, g_ph}, {1'b0, 16'd2, 2'd2});
        chk(g_hb == 1'b1, "R9 host_busy high at count", g_hb, 1);
        chk(dn_cyc < 80, "R3 no stall on direct entry", dn_cyc, 80);
        run(16'd5);
        chk(!g_err && g_cnt == 1 && g_ph == 2'd1, "R8 remainder early end", {g_err, g_cnt, g_ph}, {1'b0, 16'd1, 2'd1});
        chk(exp_q.size() == 0, "R7 all bytes delivered", exp_q.size(), 0);

        // R9 zero-byte request in transfer
        serve_en = 0; nego(); p_nd = 1'b0; settle();
        run(16'd0);
        chk(!g_err && g_cnt == 0 && g_ph == 2'd2, "R9 zero request", {g_err, g_cnt, g_ph}, {1'b0, 16'd0, 2'd2});

        // R6 nibble timeout, silent peripheral
        nego(); settle();
        run(16'd1);
        chk(g_err && g_cnt == 0 && g_ph == 2'd3, "R6 nibble timeout", {g_err, g_cnt, g_ph}, {1'b1, 16'd0, 2'd3});
        chk(dn_cyc >= TO, "R6 timeout not early", dn_cyc, TO);

        // R4 interrupt timeout
        p_nd = 1'b1; p_ack = 1'b1; nego(); settle();
        run(16'd1);
        chk(!g_err && g_ph == 2'd1, "R5 idle before interrupt test", {g_err, g_ph}, {1'b0, 2'd1});
        p_nd = 1'b0; settle();
        run(16'd1);
        chk(g_err && g_ph == 2'd3, "R4 interrupt timeout", {g_err, g_ph}, {1'b1, 2'd3});
        chk(dn_cyc >= TO, "R4 timeout not early", dn_cyc, TO);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule